// File: doc/BRIEF.md
# Impedance Sweep Host Sequencer

This block is a host-side controller that drives an impedance measurement peripheral over a byte-wide register bus. The bus has an address, write data, read data, separate write and read strobes, and a ready return. After a single start pulse, the controller performs the whole frequency sweep with no further help from the host. It puts the peripheral into a known state and loads the start frequency, the frequency step, the point count and the settling count. It then initialises the peripheral, waits a programmable number of cycles, and starts the sweep. For each point it polls the status register, reads the four result bytes, and places the real and imaginary words on a one-cycle result stream.

Averaging is optional. With a non-zero repeat count, each frequency is measured that many extra times before the controller steps to the next frequency. Every measurement appears on the result stream, so a downstream unit can accumulate them. When the peripheral reports the end of the sweep, the controller powers it down and returns to idle. The first sweep after reset issues a full peripheral reset. Later sweeps put the peripheral in standby and reprogram it.

Top module: `imp_sweep_seq`

## Requirements
- R1: While reset is asserted and after it is released without a start pulse, `bus_wr`, `bus_rd`, `busy` and `res_valid` are all low.
- R2: The first sweep after reset begins with a write of 0x10 to address 0x81. Every later sweep without an intervening reset begins instead with a write of 0xB0 (standby) to address 0x80.
- R3: The controller then makes ten writes, most significant byte first in each field: start frequency (24 bits) to 0x82, 0x83, 0x84; step (24 bits) to 0x85, 0x86, 0x87; point count (16 bits) to 0x88, 0x89; settling count (16 bits) to 0x8A, 0x8B. It then writes 0x11 to 0x80.
- R4: After the 0x11 write completes, both strobes stay low for exactly `cfg_init_wait`+1 cycles. The next transaction is a write of 0x21 to 0x80.
- R5: After each 0x21, 0x41 or 0x31 command, the controller reads status address 0x8F repeatedly until a read returns bit 1 set. It ignores the other status bits during this polling. It then reads 0x94, 0x95, 0x96 and 0x97, in that order.
- R6: `res_valid` is high for one cycle, in the cycle after the 0x97 read completes. `res_real` is {byte 0x94, byte 0x95} and `res_imag` is {byte 0x96, byte 0x97}.
- R7: Each frequency is measured `cfg_avg_reps`+1 times. Between measurements at the same frequency, the controller writes 0x41 to 0x80.
- R8: After the last measurement at a frequency, the controller reads 0x8F once. If bit 2 is set, it writes 0xA0 to 0x80 and ends the sweep. Otherwise it writes 0x31 to 0x80 and measures the next frequency.
- R9: A strobe holds its address, data and direction unchanged until a clock edge at which `bus_ready` is high, which completes the transaction. `bus_wr` and `bus_rd` are never high together.
- R10: `busy` rises in the cycle after an accepted start and falls after the 0xA0 write completes. The configuration inputs are sampled at the start. A start pulse or a configuration change while busy has no effect on the sweep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, accepted when idle |
| cfg_start_freq | input | 24 | Start frequency code |
| cfg_step_freq | input | 24 | Frequency step code |
| cfg_points | input | 16 | Number of frequency increments |
| cfg_settle | input | 16 | Settling cycle count for the peripheral |
| cfg_avg_reps | input | AVG_W | Extra measurements per frequency |
| cfg_init_wait | input | WAIT_W | Idle cycles after initialisation |
| bus_addr | output | 8 | Register address |
| bus_wdata | output | 8 | Write data |
| bus_wr | output | 1 | Write strobe |
| bus_rd | output | 1 | Read strobe |
| bus_rdata | input | 8 | Read data, valid with ready during a read |
| bus_ready | input | 1 | Completes the current transaction |
| busy | output | 1 | Sweep in progress |
| res_valid | output | 1 | Result word pair valid |
| res_real | output | 16 | Real part of a measurement |
| res_imag | output | 16 | Imaginary part of a measurement |

## Verification
A wrong state or index shows up at the next completed bus transaction as a wrong address, direction or command byte. The bench compares that transaction against its expected list. A repeat counter that is off by one shows up one measurement late, as an extra or missing 0x41 write before the status check. A wrong wait count shows in the length of the idle gap before the 0x21 write. Byte capture errors show on the next `res_valid` pulse as a mismatched word.

// File: rtl/imp_seq_pkg.sv
package imp_seq_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_CFG, S_WAIT, S_CMD, S_POLL, S_RES, S_STAT
  } seq_state_t;

  // register addresses used by the peripheral
  localparam logic [7:0] A_CTRL   = 8'h80;
  localparam logic [7:0] A_RST    = 8'h81;
  localparam logic [7:0] A_FSTART = 8'h82;
  localparam logic [7:0] A_FSTEP  = 8'h85;
  localparam logic [7:0] A_NINCR  = 8'h88;
  localparam logic [7:0] A_NSETL  = 8'h8A;
  localparam logic [7:0] A_STATUS = 8'h8F;
  localparam logic [7:0] A_RESULT = 8'h94;

  // command codes
  localparam logic [7:0] C_RESET  = 8'h10;
  localparam logic [7:0] C_INIT   = 8'h11;
  localparam logic [7:0] C_START  = 8'h21;
  localparam logic [7:0] C_NEXT   = 8'h31;
  localparam logic [7:0] C_REPEAT = 8'h41;
  localparam logic [7:0] C_PDOWN  = 8'hA0;
  localparam logic [7:0] C_STBY   = 8'hB0;

  localparam int BIT_VALID  = 1;
  localparam int BIT_DONE   = 2;
  localparam int FREQ_BYTES = 3;
  localparam int CNT_BYTES  = 2;
  localparam int RES_BYTES  = 4;
  localparam int FREQ_W     = FREQ_BYTES * 8;
  localparam int CNT_W      = CNT_BYTES * 8;
  localparam int CFG_LEN    = 2 + 2 * FREQ_BYTES + 2 * CNT_BYTES;
endpackage

// File: rtl/imp_seq_cfg_sel.sv
module imp_seq_cfg_sel
  import imp_seq_pkg::*;
#(
  parameter int IDX_W = $clog2(CFG_LEN)
) (
  input  logic [IDX_W-1:0]  idx,
  input  logic              primed,
  input  logic [FREQ_W-1:0] f_start,
  input  logic [FREQ_W-1:0] f_step,
  input  logic [CNT_W-1:0]  n_incr,
  input  logic [CNT_W-1:0]  n_settle,
  output logic [7:0]        addr,
  output logic [7:0]        data
);
  localparam int B_STEP = 1 + FREQ_BYTES;
  localparam int B_INCR = B_STEP + FREQ_BYTES;
  localparam int B_SETL = B_INCR + CNT_BYTES;
  localparam int B_INIT = B_SETL + CNT_BYTES;

  always_comb begin
    int i;
    int k;
    i    = int'(idx);
    k    = 0;
    addr = A_CTRL;
    data = C_INIT;
    if (i == 0) begin
      addr = primed ? A_CTRL : A_RST;
      data = primed ? C_STBY : C_RESET;
    end else if (i < B_STEP) begin
      k    = i - 1;
      addr = A_FSTART + 8'(k);
      data = f_start[(FREQ_BYTES-1-k)*8 +: 8];
    end else if (i < B_INCR) begin
      k    = i - B_STEP;
      addr = A_FSTEP + 8'(k);
      data = f_step[(FREQ_BYTES-1-k)*8 +: 8];
    end else if (i < B_SETL) begin
      k    = i - B_INCR;
      addr = A_NINCR + 8'(k);
      data = n_incr[(CNT_BYTES-1-k)*8 +: 8];
    end else if (i < B_INIT) begin
      k    = i - B_SETL;
      addr = A_NSETL + 8'(k);
      data = n_settle[(CNT_BYTES-1-k)*8 +: 8];
    end
  end
endmodule

// File: rtl/imp_seq_timer.sv
module imp_seq_timer #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] val,
  input  logic         en,
  output logic         zero
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = val;
    else if (en && cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);

  // R4
  wait_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en && !load && !zero |=> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/imp_seq_capture.sv
module imp_seq_capture #(
  parameter int NB = 4,
  parameter int SW = $clog2(NB)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [SW-1:0] sel,
  input  logic [7:0]    din,
  output logic [NB*8-1:0] dout
);
  for (genvar g = 0; g < NB; g++) begin : g_byte
    logic [7:0] byte_q;
    always_ff @(posedge clk) begin
      if (wr_en && sel == SW'(g)) byte_q <= din;
    end
    assign dout[(NB-1-g)*8 +: 8] = byte_q;
  end
endmodule

// File: rtl/imp_sweep_seq.sv
module imp_sweep_seq
  import imp_seq_pkg::*;
#(
  parameter int WAIT_W = 20,
  parameter int AVG_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [FREQ_W-1:0] cfg_start_freq,
  input  logic [FREQ_W-1:0] cfg_step_freq,
  input  logic [CNT_W-1:0]  cfg_points,
  input  logic [CNT_W-1:0]  cfg_settle,
  input  logic [AVG_W-1:0]  cfg_avg_reps,
  input  logic [WAIT_W-1:0] cfg_init_wait,
  output logic [7:0]        bus_addr,
  output logic [7:0]        bus_wdata,
  output logic              bus_wr,
  output logic              bus_rd,
  input  logic [7:0]        bus_rdata,
  input  logic              bus_ready,
  output logic              busy,
  output logic              res_valid,
  output logic [15:0]       res_real,
  output logic [15:0]       res_imag
);
  localparam int IDX_W = $clog2(CFG_LEN);
  localparam int BI_W  = $clog2(RES_BYTES);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CFG_LEN - 1);
  localparam logic [BI_W-1:0]  LAST_B   = BI_W'(RES_BYTES - 1);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_m_q, rst_s_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_s_q <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_s_q <= rst_m_q;
    end
  end

  seq_state_t state_q, state_d;
  logic [IDX_W-1:0] cfg_idx_q, cfg_idx_d;
  logic [BI_W-1:0]  bidx_q, bidx_d;
  logic [7:0]       cmd_q, cmd_d;
  logic [AVG_W-1:0] rep_q, rep_d;
  logic             primed_q, primed_d;
  logic             res_valid_q, res_valid_d;
  logic             accept, tmr_load, tmr_zero, cap_en, txn_done;

  logic [FREQ_W-1:0] fstart_q, fstep_q;
  logic [CNT_W-1:0]  pts_q, settle_q;
  logic [AVG_W-1:0]  avg_q;
  logic [WAIT_W-1:0] wait_q;
  logic [7:0]        cfg_addr, cfg_data;
  logic [RES_BYTES*8-1:0] res_word;

  always_ff @(posedge clk) begin
    if (accept) begin
      fstart_q <= cfg_start_freq;
      fstep_q  <= cfg_step_freq;
      pts_q    <= cfg_points;
      settle_q <= cfg_settle;
      avg_q    <= cfg_avg_reps;
      wait_q   <= cfg_init_wait;
    end
  end

  imp_seq_cfg_sel #(.IDX_W(IDX_W)) u_cfg (
    .idx(cfg_idx_q), .primed(primed_q), .f_start(fstart_q), .f_step(fstep_q),
    .n_incr(pts_q), .n_settle(settle_q), .addr(cfg_addr), .data(cfg_data)
  );

  imp_seq_timer #(.W(WAIT_W)) u_tmr (
    .clk(clk), .rst_n(rst_s_q), .load(tmr_load), .val(wait_q),
    .en(state_q == S_WAIT), .zero(tmr_zero)
  );

  imp_seq_capture #(.NB(RES_BYTES)) u_cap (
    .clk(clk), .wr_en(cap_en), .sel(bidx_q), .din(bus_rdata), .dout(res_word)
  );

  // bus drive from state
  always_comb begin
    bus_wr    = 1'b0;
    bus_rd    = 1'b0;
    bus_addr  = A_CTRL;
    bus_wdata = 8'h00;
    case (state_q)
      S_CFG:  begin bus_wr = 1'b1; bus_addr = cfg_addr; bus_wdata = cfg_data; end
      S_CMD:  begin bus_wr = 1'b1; bus_wdata = cmd_q; end
      S_POLL, S_STAT: begin bus_rd = 1'b1; bus_addr = A_STATUS; end
      S_RES:  begin bus_rd = 1'b1; bus_addr = A_RESULT + 8'(bidx_q); end
      default: ;
    endcase
  end

  assign txn_done = (bus_wr | bus_rd) & bus_ready;

  always_comb begin
    state_d     = state_q;
    cfg_idx_d   = cfg_idx_q;
    bidx_d      = bidx_q;
    cmd_d       = cmd_q;
    rep_d       = rep_q;
    primed_d    = primed_q;
    res_valid_d = 1'b0;
    accept      = 1'b0;
    tmr_load    = 1'b0;
    cap_en      = 1'b0;
    case (state_q)
      S_IDLE: if (start) begin
        accept    = 1'b1;
        cfg_idx_d = '0;
        state_d   = S_CFG;
      end
      S_CFG: if (txn_done) begin
        if (cfg_idx_q == LAST_IDX) begin
          tmr_load = 1'b1;
          state_d  = S_WAIT;
        end else begin
          cfg_idx_d = cfg_idx_q + 1'b1;
        end
      end
      S_WAIT: if (tmr_zero) begin
        cmd_d   = C_START;
        rep_d   = avg_q;
        state_d = S_CMD;
      end
      S_CMD: if (txn_done) begin
        if (cmd_q == C_PDOWN) begin
          primed_d = 1'b1;
          state_d  = S_IDLE;
        end else begin
          state_d = S_POLL;
        end
      end
      S_POLL: if (txn_done && bus_rdata[BIT_VALID]) begin
        bidx_d  = '0;
        state_d = S_RES;
      end
      S_RES: if (txn_done) begin
        cap_en = 1'b1;
        if (bidx_q == LAST_B) begin
          res_valid_d = 1'b1;
          if (rep_q != '0) begin
            rep_d   = rep_q - 1'b1;
            cmd_d   = C_REPEAT;
            state_d = S_CMD;
          end else begin
            state_d = S_STAT;
          end
        end else begin
          bidx_d = bidx_q + 1'b1;
        end
      end
      S_STAT: if (txn_done) begin
        if (bus_rdata[BIT_DONE]) begin
          cmd_d = C_PDOWN;
        end else begin
          cmd_d = C_NEXT;
          rep_d = avg_q;
        end
        state_d = S_CMD;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s_q) begin
    if (!rst_s_q) begin
      state_q     <= S_IDLE;
      cfg_idx_q   <= '0;
      bidx_q      <= '0;
      cmd_q       <= C_START;
      rep_q       <= '0;
      primed_q    <= 1'b0;
      res_valid_q <= 1'b0;
    end else begin
      state_q     <= state_d;
      cfg_idx_q   <= cfg_idx_d;
      bidx_q      <= bidx_d;
      cmd_q       <= cmd_d;
      rep_q       <= rep_d;
      primed_q    <= primed_d;
      res_valid_q <= res_valid_d;
    end
  end

  assign busy      = (state_q != S_IDLE);
  assign res_valid = res_valid_q;
  assign res_real  = res_word[31:16];
  assign res_imag  = res_word[15:0];

  // R9
  bus_excl_chk: assert property (@(posedge clk) disable iff (!rst_s_q)
    !(bus_wr && bus_rd));

  // R9
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_s_q)
    (bus_wr || bus_rd) && !bus_ready |=>
      $stable(bus_addr) && $stable(bus_wdata) && $stable(bus_wr) && $stable(bus_rd));

  // R6
  res_src_chk: assert property (@(posedge clk) disable iff (!rst_s_q)
    res_valid |-> $past(bus_rd && bus_ready && bus_addr == A_RESULT + 8'd3));

  // R10
  res_busy_chk: assert property (@(posedge clk) disable iff (!rst_s_q)
    res_valid |-> busy);

  // R8
  pdown_end_chk: assert property (@(posedge clk) disable iff (!rst_s_q)
    $fell(busy) |-> $past(bus_wr && bus_ready && bus_addr == A_CTRL && bus_wdata == C_PDOWN));

  // R10
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_s_q)
    start && !busy |=> busy);
endmodule

// File: tb/imp_sweep_seq_tb.sv
`timescale 1ns/1ps
module imp_sweep_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [23:0] cfg_start_freq, cfg_step_freq;
  logic [15:0] cfg_points, cfg_settle;
  logic [7:0]  cfg_avg_reps;
  logic [19:0] cfg_init_wait;
  logic [7:0]  bus_addr, bus_wdata, bus_rdata;
  logic        bus_wr, bus_rd, bus_ready;
  logic        busy, res_valid;
  logic [15:0] res_real, res_imag;

  always #2.5 clk = ~clk;

  imp_sweep_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_start_freq(cfg_start_freq), .cfg_step_freq(cfg_step_freq),
    .cfg_points(cfg_points), .cfg_settle(cfg_settle),
    .cfg_avg_reps(cfg_avg_reps), .cfg_init_wait(cfg_init_wait),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .bus_ready(bus_ready),
    .busy(busy), .res_valid(res_valid), .res_real(res_real), .res_imag(res_imag)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  logic [16:0] exp_txn[$];
  string       exp_tag[$];
  logic [31:0] exp_res[$];
  int          exp_meas = 0;

  // peripheral model state
  int          poll_cnt = 0;
  int          pt_idx   = 0;
  int          meas     = 0;
  logic [15:0] dev_incr = '0;
  int          rdy_seq  = 0;
  bit          p_valid  = 0;
  logic        p_wr;
  logic [7:0]  p_addr, p_data;
  bit          h_act = 0;
  logic        h_wr, h_rd;
  logic [7:0]  h_addr, h_data;
  bit          gap_arm = 0;
  int          gap = 0;
  int          cur_wait = 0;

  function automatic logic [15:0] m_real(int m);
    return 16'h1234 + 16'(m * 257);
  endfunction
  function automatic logic [15:0] m_imag(int m);
    return 16'hF000 - 16'(m * 51);
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s actual=0x%0h expected=0x%0h", req, what, act, expv);
    end
  endtask

  task automatic pw(logic [7:0] a, logic [7:0] d, string tag);
    exp_txn.push_back({1'b1, a, d});
    exp_tag.push_back(tag);
  endtask
  task automatic pr(logic [7:0] a, string tag);
    exp_txn.push_back({1'b0, a, 8'h00});
    exp_tag.push_back(tag);
  endtask

  task automatic build_exp(bit first, logic [23:0] fs, logic [23:0] st,
                           logic [15:0] np, logic [15:0] sc, int av);
    if (first) pw(8'h81, 8'h10, "R2"); else pw(8'h80, 8'hB0, "R2");
    for (int k = 0; k < 3; k++) pw(8'h82 + 8'(k), fs[(2-k)*8 +: 8], "R3");
    for (int k = 0; k < 3; k++) pw(8'h85 + 8'(k), st[(2-k)*8 +: 8], "R3");
    for (int k = 0; k < 2; k++) pw(8'h88 + 8'(k), np[(1-k)*8 +: 8], "R3");
    for (int k = 0; k < 2; k++) pw(8'h8A + 8'(k), sc[(1-k)*8 +: 8], "R3");
    pw(8'h80, 8'h11, "R3");
    pw(8'h80, 8'h21, "R4");
    for (int p = 0; p <= int'(np); p++) begin
      for (int r = 0; r <= av; r++) begin
        for (int q = 0; q < 3; q++) pr(8'h8F, "R5");
        for (int b = 0; b < 4; b++) pr(8'h94 + 8'(b), "R5");
        exp_res.push_back({m_real(exp_meas), m_imag(exp_meas)});
        exp_meas++;
        if (r < av) pw(8'h80, 8'h41, "R7");  // R7 repeat at same frequency
      end
      pr(8'h8F, "R8");
      if (p == int'(np)) pw(8'h80, 8'hA0, "R8"); else pw(8'h80, 8'h31, "R8");
    end
  endtask

  task automatic process_txn();
    logic [16:0] e;
    string t;
    if (exp_txn.size() == 0) begin
      chk(0, "R2", "unexpected transaction", {15'h0, p_wr, p_addr, p_data}, 0);
    end else begin
      e = exp_txn.pop_front();
      t = exp_tag.pop_front();
      chk(e[16] == p_wr && e[15:8] == p_addr && (!p_wr || e[7:0] == p_data), t,
          "bus transaction {wr,addr,data}", {15'h0, p_wr, p_addr, p_data}, {15'h0, e});
    end
    if (p_wr) begin
      if (p_addr == 8'h88) dev_incr[15:8] = p_data;
      if (p_addr == 8'h89) dev_incr[7:0]  = p_data;
      if (p_addr == 8'h80) begin
        if (p_data == 8'h21 || p_data == 8'h41 || p_data == 8'h31) poll_cnt = 0;
        if (p_data == 8'h21) pt_idx = 0;
        if (p_data == 8'h31) pt_idx++;
        if (p_data == 8'h11) begin gap_arm = 1; gap = 0; end
      end
    end else begin
      if (p_addr == 8'h8F) poll_cnt++;
      if (p_addr == 8'h97) meas++;
    end
    p_valid = 0;
  endtask

  // bus responder and per-cycle comparison
  always @(negedge clk) begin
    logic strobe, rdy;
    logic [31:0] er;
    if (!rst_n) begin
      bus_ready = 1'b0;
      p_valid = 0;
      h_act = 0;
      gap_arm = 0;
    end else begin
      if (p_valid) process_txn();
      strobe = bus_wr | bus_rd;
      if (strobe) chk(!(bus_wr && bus_rd), "R9", "both strobes high", {bus_wr, bus_rd}, 2'b00);
      if (h_act)
        chk(bus_wr == h_wr && bus_rd == h_rd && bus_addr == h_addr && (!h_wr || bus_wdata == h_data),
            "R9", "held transaction changed", {14'h0, bus_wr, bus_rd, bus_addr, bus_wdata},
            {14'h0, h_wr, h_rd, h_addr, h_data});
      if (gap_arm) begin
        if (strobe) begin
          chk(gap == cur_wait + 1, "R4", "idle cycles after init", gap, cur_wait + 1);
          gap_arm = 0;
        end else gap++;
      end
      rdy = strobe && (rdy_seq % 4 != 2);
      rdy_seq++;
      bus_rdata = 8'h00;
      if (bus_rd) begin
        case (bus_addr)
          8'h8F: bus_rdata = 8'h01 | (poll_cnt >= 2 ? 8'h02 : 8'h00)
                                   | (pt_idx == int'(dev_incr) ? 8'h04 : 8'h00);
          8'h94: bus_rdata = m_real(meas)[15:8];
          8'h95: bus_rdata = m_real(meas)[7:0];
          8'h96: bus_rdata = m_imag(meas)[15:8];
          8'h97: bus_rdata = m_imag(meas)[7:0];
          default: bus_rdata = 8'hEE;
        endcase
      end
      bus_ready = rdy;
      if (rdy) begin
        p_valid = 1;
        p_wr = bus_wr;
        p_addr = bus_addr;
        p_data = bus_wdata;
      end
      h_act = strobe && !rdy;
      h_wr = bus_wr; h_rd = bus_rd; h_addr = bus_addr; h_data = bus_wdata;
      if (res_valid) begin
        if (exp_res.size() == 0) chk(0, "R6", "unexpected result", {res_real, res_imag}, 0);
        else begin
          er = exp_res.pop_front();
          chk({res_real, res_imag} == er, "R6", "result words", {res_real, res_imag}, er);
        end
      end
    end
  end

  task automatic run_sweep(bit first, logic [23:0] fs, logic [23:0] st, logic [15:0] np,
                           logic [15:0] sc, int av, int wt, bit disturb);
    int n;
    @(negedge clk);
    cfg_start_freq = fs; cfg_step_freq = st; cfg_points = np; cfg_settle = sc;
    cfg_avg_reps = 8'(av); cfg_init_wait = 20'(wt);
    cur_wait = wt;
    build_exp(first, fs, st, np, sc, av);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy, "R10", "busy after start", busy, 1);
    if (disturb) begin
      repeat (6) @(negedge clk);
      // R10: config changes and a second start while busy must not matter
      cfg_start_freq = ~fs; cfg_points = np + 16'd3; cfg_avg_reps = 8'd0;
      cfg_init_wait = 20'(wt + 7); cfg_settle = ~sc;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    n = 0;
    while (busy && n < 20000) begin @(negedge clk); n++; end
    @(negedge clk);
    chk(!busy, "R10", "busy cleared at end", busy, 0);
    chk(exp_txn.size() == 0, "R8", "transactions left", exp_txn.size(), 0);
    chk(exp_res.size() == 0, "R6", "results left", exp_res.size(), 0);
    repeat (3) @(negedge clk);
    chk(!bus_wr && !bus_rd && !res_valid, "R1", "quiet after sweep", {bus_wr, bus_rd, res_valid}, 0);
  endtask

  task automatic check_quiet(string what);
    chk(!bus_wr && !bus_rd && !busy && !res_valid, "R1", what,
        {bus_wr, bus_rd, busy, res_valid}, 0);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0;
    cfg_start_freq = '0; cfg_step_freq = '0; cfg_points = '0; cfg_settle = '0;
    cfg_avg_reps = '0; cfg_init_wait = '0;
    repeat (3) @(negedge clk);
    check_quiet("outputs during reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_quiet("outputs after reset release");
    // R2 first sweep uses full reset, plain sweep
    run_sweep(1, 24'h00F3C5, 24'h0079E2, 16'd3, 16'd12, 0, 5, 0);
    // standby path, averaging, disturbance while busy
    run_sweep(0, 24'h123456, 24'h00ABCD, 16'd2, 16'h0102, 2, 0, 1);
    // single point with one repeat
    run_sweep(0, 24'hFEDCBA, 24'h000001, 16'd0, 16'hA55A, 1, 3, 0);
    // reset again: next sweep must use full reset once more (R2)
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check_quiet("outputs during second reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    run_sweep(1, 24'h0A0B0C, 24'h0D0E0F, 16'd1, 16'd7, 0, 2, 0);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #750000;
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: run did not finish actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule